// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page translations for a processor's memory pipeline. Every slot holds a virtual page tag, an address-space number with a global flag, a physical page number, read and write enable masks (one bit per privilege mode), read-trap and write-trap flags, and a valid bit. A lookup presents a page number and the current address-space number. One clock later the block returns hit or miss, the slot index, and the stored fields of the matching slot. Checking the permissions and raising faults are left to the logic that consumes these outputs.

A short list of recently hit slot indices is checked before the full array, in priority order. A hit that comes from the full search is pushed to the front of that list. Any fill or flush empties the list. New translations always go to the slot named by a single round-robin victim pointer, and any valid entry there is evicted. Maintenance commands can wipe the whole array, drop only the non-global entries, or drop the entries that match one page and address space. A read port shows the slot under the victim pointer, and a step input moves that pointer on.

Top module: `assoc_xlate_buf`

## Requirements
- R1: A slot matches only when all three of these hold: it is valid, its tag equals the lookup page number, and either its global flag is set or its stored address-space number equals the lookup one.
- R2: `lk_vld` is high exactly one cycle after a cycle with `lk_req` high. The result outputs describe the chosen slot on a hit. On a miss, or when `lk_vld` is low, all result outputs are zero.
- R3: A fill writes the slot at `rd_ptr` and evicts any previous content. The tag is `ins_va[VPN_W+OFFS_W-1:OFFS_W]`, the slot becomes valid, and `rd_ptr` then advances by one.
- R4: Whenever `rd_ptr` advances from ENTRIES-1, it goes to 0.
- R5: A wipe clears every field of every slot and sets `rd_ptr` to 0.
- R6: A local drop invalidates every slot whose global flag is clear. Global slots are kept.
- R7: A page drop invalidates every slot that would match (by the rule in R1) the page number in `flush_va[VPN_W+OFFS_W-1:OFFS_W]` together with `flush_asn`.
- R8: If several slots match in the full search, the lowest index is returned.
- R9: The recently-hit list (RECENT slot indices, slot 0 first) is checked before the full search. When the full search produces a hit, that index is pushed into slot 0, and the older slots shift down by one.
- R10: Any fill, wipe, local drop or page drop empties the recently-hit list. A step does not empty it.
- R11: The `rd_*` outputs always show the slot at `rd_ptr`. A step (`rd_adv`) moves `rd_ptr` on by one, with wrap, and leaves the slots unchanged.
- R12: Only one command takes effect per cycle. The priority order is wipe, fill, local drop, page drop, step. A lookup in the same cycle sees the array as it was before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Slot index of the hit |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODE_W | Read enable mask of the hit |
| lk_wr_en | output | MODE_W | Write enable mask of the hit |
| lk_rd_trap | output | 1 | Read-trap flag of the hit |
| lk_wr_trap | output | 1 | Write-trap flag of the hit |
| lk_glob | output | 1 | Global flag of the hit |
| ins_req | input | 1 | Fill command |
| ins_va | input | VPN_W+OFFS_W | Virtual address of the fill; the upper VPN_W bits become the tag |
| ins_asn | input | ASN_W | Address-space number to store |
| ins_glob | input | 1 | Global flag to store |
| ins_ppn | input | PPN_W | Physical page to store |
| ins_rd_en | input | MODE_W | Read enable mask to store |
| ins_wr_en | input | MODE_W | Write enable mask to store |
| ins_rd_trap | input | 1 | Read-trap flag to store |
| ins_wr_trap | input | 1 | Write-trap flag to store |
| flush_all | input | 1 | Wipe command |
| flush_local | input | 1 | Drop non-global slots |
| flush_page | input | 1 | Drop slots matching one page and address space |
| flush_va | input | VPN_W+OFFS_W | Address for the page drop |
| flush_asn | input | ASN_W | Address-space number for the page drop |
| rd_adv | input | 1 | Step the victim pointer |
| rd_ptr | output | IDX_W | Victim pointer |
| rd_valid | output | 1 | Valid bit of the slot at the pointer |
| rd_vpn | output | VPN_W | Tag of the slot at the pointer |
| rd_asn | output | ASN_W | Address-space number of the slot at the pointer |
| rd_glob | output | 1 | Global flag of the slot at the pointer |
| rd_ppn | output | PPN_W | Physical page of the slot at the pointer |

## Verification
Lookups are tried with three kinds of key against the same stored slots. One key matches on both tag and address space. One matches on the tag only, and its address-space number is wrong. One has an unmatched tag. Together they separate the address-space test from the tag test, and a global slot under a foreign address-space number shows that the global flag overrides the address-space test. Two slots with the same tag, one global and one local, expose the ordering. A fresh search must return the lower index, but once the global slot has been promoted into the recently-hit list it must win. After an unrelated page drop, and again after an unrelated fill, the lower index must come back, which shows the list was emptied. Fills past the last slot, commands raised together, and steps of the read port check the victim pointer's wrap, eviction and priority.

// File: rtl/xb_pkg.sv
package xb_pkg;

   typedef enum logic [2:0] {
      XB_IDLE,
      XB_WIPE,
      XB_FILL,
      XB_DROP_LOCAL,
      XB_DROP_PAGE,
      XB_STEP
   } xb_op_e;

   // One command per cycle, fixed priority.
   function automatic xb_op_e xb_pick_op(input logic wipe, input logic fill,
                                         input logic drop_local, input logic drop_page,
                                         input logic step);
      if (wipe)            return XB_WIPE;
      else if (fill)       return XB_FILL;
      else if (drop_local) return XB_DROP_LOCAL;
      else if (drop_page)  return XB_DROP_PAGE;
      else if (step)       return XB_STEP;
      else                 return XB_IDLE;
   endfunction

endpackage

// File: rtl/xb_match.sv
module xb_match #(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int ASN_W = 8
)(
   input  logic [N-1:0]            ent_vld,
   input  logic [N-1:0]            ent_glb,
   input  logic [N-1:0][VPN_W-1:0] ent_vpn,
   input  logic [N-1:0][ASN_W-1:0] ent_asn,
   input  logic [VPN_W-1:0]        key_vpn,
   input  logic [ASN_W-1:0]        key_asn,
   output logic [N-1:0]            hit_vec
);

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = ent_vld[i] && (ent_vpn[i] == key_vpn) &&
                          (ent_glb[i] || (ent_asn[i] == key_asn));
   end

endmodule

// File: rtl/xb_first.sv
module xb_first #(
   parameter int N     = 8,
   parameter int IDX_W = 3
)(
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   // Scan downward so the lowest set bit is the last one written.
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/xb_recent.sv
module xb_recent #(
   parameter int N     = 8,
   parameter int DEPTH = 3,
   parameter int IDX_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             probe,
   input  logic [N-1:0]     match_vec,
   input  logic             full_any,
   input  logic [IDX_W-1:0] full_idx,
   output logic             sel_hit,
   output logic [IDX_W-1:0] sel_idx
);

   logic [DEPTH-1:0]            s_vld;
   logic [DEPTH-1:0][IDX_W-1:0] s_idx;
   logic                        sc_any;
   logic [IDX_W-1:0]            sc_pick;
   logic                        promote;

   always_comb begin
      sc_any  = 1'b0;
      sc_pick = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (s_vld[k] && match_vec[s_idx[k]]) begin
            sc_any  = 1'b1;
            sc_pick = s_idx[k];
         end
      end
   end

   assign promote = probe && !sc_any && full_any;
   assign sel_hit = sc_any || full_any;
   assign sel_idx = sc_any ? sc_pick : full_idx;

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_vld <= '0;
            s_idx <= '0;
         end else if (clear) begin
            s_vld <= '0;
         end else if (promote) begin
            s_vld <= 1'b1;
            s_idx <= full_idx;
         end
      end
   end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_vld <= '0;
            s_idx <= '0;
         end else if (clear) begin
            s_vld <= '0;
         end else if (promote) begin
            s_vld <= {s_vld[DEPTH-2:0], 1'b1};
            s_idx <= {s_idx[DEPTH-2:0], full_idx};
         end
      end
   end

endmodule

// File: rtl/assoc_xlate_buf.sv
module assoc_xlate_buf
   import xb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int OFFS_W  = 13,
   parameter int ASN_W   = 8,
   parameter int PPN_W   = 20,
   parameter int MODE_W  = 4,
   parameter int RECENT  = 3,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VA_W   = VPN_W + OFFS_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASN_W-1:0]  lk_asn,
   output logic              lk_vld,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [MODE_W-1:0] lk_rd_en,
   output logic [MODE_W-1:0] lk_wr_en,
   output logic              lk_rd_trap,
   output logic              lk_wr_trap,
   output logic              lk_glob,
   input  logic              ins_req,
   input  logic [VA_W-1:0]   ins_va,
   input  logic [ASN_W-1:0]  ins_asn,
   input  logic              ins_glob,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [MODE_W-1:0] ins_rd_en,
   input  logic [MODE_W-1:0] ins_wr_en,
   input  logic              ins_rd_trap,
   input  logic              ins_wr_trap,
   input  logic              flush_all,
   input  logic              flush_local,
   input  logic              flush_page,
   input  logic [VA_W-1:0]   flush_va,
   input  logic [ASN_W-1:0]  flush_asn,
   input  logic              rd_adv,
   output logic [IDX_W-1:0]  rd_ptr,
   output logic              rd_valid,
   output logic [VPN_W-1:0]  rd_vpn,
   output logic [ASN_W-1:0]  rd_asn,
   output logic              rd_glob,
   output logic [PPN_W-1:0]  rd_ppn
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_chk_entries
      $error("assoc_xlate_buf: ENTRIES must be at least 2");
   end
   if (RECENT < 1 || RECENT > ENTRIES) begin : g_chk_recent
      $error("assoc_xlate_buf: RECENT must lie in 1..ENTRIES");
   end
   if (VPN_W < 1 || OFFS_W < 1 || ASN_W < 1 || PPN_W < 1 || MODE_W < 1) begin : g_chk_widths
      $error("assoc_xlate_buf: field widths must be positive");
   end

   // slot storage
   logic [ENTRIES-1:0]             e_vld, e_glb, e_rtp, e_wtp;
   logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
   logic [ENTRIES-1:0][ASN_W-1:0]  e_asn;
   logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
   logic [ENTRIES-1:0][MODE_W-1:0] e_rde, e_wre;
   logic [IDX_W-1:0]               vptr, vptr_nxt;

   xb_op_e            op;
   logic              maint;
   logic [ENTRIES-1:0] lk_vec, page_vec;
   logic              full_any, sel_hit;
   logic [IDX_W-1:0]  full_idx, sel_idx;
   logic              unused_offs;

   assign unused_offs = ^{ins_va[OFFS_W-1:0], flush_va[OFFS_W-1:0]};

   assign op       = xb_pick_op(flush_all, ins_req, flush_local, flush_page, rd_adv);
   assign maint    = (op == XB_WIPE) || (op == XB_FILL) ||
                     (op == XB_DROP_LOCAL) || (op == XB_DROP_PAGE);
   assign vptr_nxt = (vptr == LAST) ? '0 : vptr + 1'b1;

   xb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
      .ent_vld (e_vld),
      .ent_glb (e_glb),
      .ent_vpn (e_vpn),
      .ent_asn (e_asn),
      .key_vpn (lk_vpn),
      .key_asn (lk_asn),
      .hit_vec (lk_vec)
   );

   xb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_pg_match (
      .ent_vld (e_vld),
      .ent_glb (e_glb),
      .ent_vpn (e_vpn),
      .ent_asn (e_asn),
      .key_vpn (flush_va[VA_W-1:OFFS_W]),
      .key_asn (flush_asn),
      .hit_vec (page_vec)
   );

   xb_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
      .req (lk_vec),
      .any (full_any),
      .idx (full_idx)
   );

   xb_recent #(.N(ENTRIES), .DEPTH(RECENT), .IDX_W(IDX_W)) u_recent (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (maint),
      .probe     (lk_req),
      .match_vec (lk_vec),
      .full_any  (full_any),
      .full_idx  (full_idx),
      .sel_hit   (sel_hit),
      .sel_idx   (sel_idx)
   );

   // slot updates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld <= '0; e_glb <= '0; e_rtp <= '0; e_wtp <= '0;
         e_vpn <= '0; e_asn <= '0; e_ppn <= '0; e_rde <= '0; e_wre <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            case (op)
               XB_WIPE: begin
                  e_vld[i] <= 1'b0; e_glb[i] <= 1'b0; e_rtp[i] <= 1'b0; e_wtp[i] <= 1'b0;
                  e_vpn[i] <= '0;   e_asn[i] <= '0;   e_ppn[i] <= '0;
                  e_rde[i] <= '0;   e_wre[i] <= '0;
               end
               XB_FILL: begin
                  if (vptr == IDX_W'(i)) begin
                     e_vld[i] <= 1'b1;
                     e_vpn[i] <= ins_va[VA_W-1:OFFS_W];
                     e_asn[i] <= ins_asn;
                     e_glb[i] <= ins_glob;
                     e_ppn[i] <= ins_ppn;
                     e_rde[i] <= ins_rd_en;
                     e_wre[i] <= ins_wr_en;
                     e_rtp[i] <= ins_rd_trap;
                     e_wtp[i] <= ins_wr_trap;
                  end
               end
               XB_DROP_LOCAL: if (!e_glb[i]) e_vld[i] <= 1'b0;
               XB_DROP_PAGE:  if (page_vec[i]) e_vld[i] <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   // victim pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             vptr <= '0;
      else if (op == XB_WIPE)                 vptr <= '0;
      else if (op == XB_FILL || op == XB_STEP) vptr <= vptr_nxt;
   end

   // registered lookup response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_vld <= 1'b0; lk_hit <= 1'b0; lk_idx <= '0; lk_ppn <= '0;
         lk_rd_en <= '0; lk_wr_en <= '0; lk_rd_trap <= 1'b0; lk_wr_trap <= 1'b0;
         lk_glob <= 1'b0;
      end else begin
         lk_vld <= lk_req;
         if (lk_req && sel_hit) begin
            lk_hit     <= 1'b1;
            lk_idx     <= sel_idx;
            lk_ppn     <= e_ppn[sel_idx];
            lk_rd_en   <= e_rde[sel_idx];
            lk_wr_en   <= e_wre[sel_idx];
            lk_rd_trap <= e_rtp[sel_idx];
            lk_wr_trap <= e_wtp[sel_idx];
            lk_glob    <= e_glb[sel_idx];
         end else begin
            lk_hit <= 1'b0; lk_idx <= '0; lk_ppn <= '0;
            lk_rd_en <= '0; lk_wr_en <= '0; lk_rd_trap <= 1'b0; lk_wr_trap <= 1'b0;
            lk_glob <= 1'b0;
         end
      end
   end

   assign rd_ptr   = vptr;
   assign rd_valid = e_vld[vptr];
   assign rd_vpn   = e_vpn[vptr];
   assign rd_asn   = e_asn[vptr];
   assign rd_glob  = e_glb[vptr];
   assign rd_ppn   = e_ppn[vptr];

endmodule

// File: rtl/xb_checker.sv
module xb_checker #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             lk_req,
   input logic             lk_vld,
   input logic             lk_hit,
   input logic             flush_all,
   input logic             ins_req,
   input logic             flush_local,
   input logic             flush_page,
   input logic             rd_adv,
   input logic [IDX_W-1:0] rd_ptr,
   input logic             rd_valid
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_vld);

   assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> (!lk_vld && !lk_hit));

   assert_wipe_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (rd_ptr == '0 && !rd_valid));

   assert_wipe_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all ##1 lk_req |=> !lk_hit);

   assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !flush_all && rd_ptr != LAST) |=> rd_ptr == $past(rd_ptr) + 1'b1);

   assert_fill_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !flush_all && rd_ptr == LAST) |=> rd_ptr == '0);

   assert_adv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_adv && !flush_all && !ins_req && !flush_local && !flush_page)
      |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));

   assert_drop_keeps_ptr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((flush_local || flush_page) && !flush_all && !ins_req) |=> $stable(rd_ptr));

endmodule

bind assoc_xlate_buf xb_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_xb_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_req      (lk_req),
   .lk_vld      (lk_vld),
   .lk_hit      (lk_hit),
   .flush_all   (flush_all),
   .ins_req     (ins_req),
   .flush_local (flush_local),
   .flush_page  (flush_page),
   .rd_adv      (rd_adv),
   .rd_ptr      (rd_ptr),
   .rd_valid    (rd_valid)
);

// File: tb/assoc_xlate_buf_bench.sv
module assoc_xlate_buf_bench;

   localparam int N      = 4;
   localparam int VPN_W  = 20;
   localparam int OFFS_W = 13;
   localparam int ASN_W  = 8;
   localparam int PPN_W  = 20;
   localparam int MODE_W = 4;
   localparam int IDX_W  = 2;
   localparam int VA_W   = VPN_W + OFFS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic              lk_req = 0;
   logic [VPN_W-1:0]  lk_vpn = '0;
   logic [ASN_W-1:0]  lk_asn = '0;
   logic              lk_vld, lk_hit, lk_rd_trap, lk_wr_trap, lk_glob;
   logic [IDX_W-1:0]  lk_idx;
   logic [PPN_W-1:0]  lk_ppn;
   logic [MODE_W-1:0] lk_rd_en, lk_wr_en;
   logic              ins_req = 0;
   logic [VA_W-1:0]   ins_va = '0;
   logic [ASN_W-1:0]  ins_asn = '0;
   logic              ins_glob = 0;
   logic [PPN_W-1:0]  ins_ppn = '0;
   logic [MODE_W-1:0] ins_rd_en = '0, ins_wr_en = '0;
   logic              ins_rd_trap = 0, ins_wr_trap = 0;
   logic              flush_all = 0, flush_local = 0, flush_page = 0;
   logic [VA_W-1:0]   flush_va = '0;
   logic [ASN_W-1:0]  flush_asn = '0;
   logic              rd_adv = 0;
   logic [IDX_W-1:0]  rd_ptr;
   logic              rd_valid, rd_glob;
   logic [VPN_W-1:0]  rd_vpn;
   logic [ASN_W-1:0]  rd_asn;
   logic [PPN_W-1:0]  rd_ppn;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   assoc_xlate_buf #(.ENTRIES(N), .VPN_W(VPN_W), .OFFS_W(OFFS_W), .ASN_W(ASN_W),
                     .PPN_W(PPN_W), .MODE_W(MODE_W), .RECENT(3)) u_assoc_xlate_buf (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
      .lk_vld(lk_vld), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
      .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_rd_trap(lk_rd_trap),
      .lk_wr_trap(lk_wr_trap), .lk_glob(lk_glob),
      .ins_req(ins_req), .ins_va(ins_va), .ins_asn(ins_asn), .ins_glob(ins_glob),
      .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
      .ins_rd_trap(ins_rd_trap), .ins_wr_trap(ins_wr_trap),
      .flush_all(flush_all), .flush_local(flush_local), .flush_page(flush_page),
      .flush_va(flush_va), .flush_asn(flush_asn),
      .rd_adv(rd_adv), .rd_ptr(rd_ptr), .rd_valid(rd_valid), .rd_vpn(rd_vpn),
      .rd_asn(rd_asn), .rd_glob(rd_glob), .rd_ppn(rd_ppn)
   );

   task automatic chk(input string rq, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic fill(input logic [VPN_W-1:0] vpn, input logic [OFFS_W-1:0] off,
                       input logic [ASN_W-1:0] asn, input logic glb,
                       input logic [PPN_W-1:0] ppn);
      @(negedge clk);
      ins_req = 1; ins_va = {vpn, off}; ins_asn = asn; ins_glob = glb; ins_ppn = ppn;
      ins_rd_en = 4'h3; ins_wr_en = 4'h1; ins_rd_trap = 0; ins_wr_trap = 1;
      @(negedge clk);
      ins_req = 0;
   endtask

   task automatic wipe();
      @(negedge clk); flush_all = 1;
      @(negedge clk); flush_all = 0;
   endtask

   task automatic drop_local();
      @(negedge clk); flush_local = 1;
      @(negedge clk); flush_local = 0;
   endtask

   task automatic drop_page(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn);
      @(negedge clk); flush_page = 1; flush_va = {vpn, 13'h0155}; flush_asn = asn;
      @(negedge clk); flush_page = 0;
   endtask

   task automatic step();
      @(negedge clk); rd_adv = 1;
      @(negedge clk); rd_adv = 0;
   endtask

   task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn);
      @(negedge clk); lk_req = 1; lk_vpn = vpn; lk_asn = asn;
      @(negedge clk); lk_req = 0;
   endtask

   task automatic t_reset();
      chk("R5", "reset rd_ptr", 64'(rd_ptr), 0);
      chk("R5", "reset rd_valid", 64'(rd_valid), 0);
      chk("R2", "reset lk_vld", 64'(lk_vld), 0);
      look(20'h11, 8'h05);
      chk("R2", "lk_vld after req", 64'(lk_vld), 1);
      chk("R2", "empty miss", 64'(lk_hit), 0);
      chk("R2", "miss ppn zero", 64'(lk_ppn), 0);
   endtask

   task automatic t_basic();
      wipe();
      fill(20'h11, 13'h1ABC, 8'h05, 0, 20'hA1);
      chk("R3", "ptr after fill", 64'(rd_ptr), 1);
      look(20'h11, 8'h05);
      chk("R1", "own asn hit", 64'(lk_hit), 1);
      chk("R2", "hit idx", 64'(lk_idx), 0);
      chk("R2", "hit ppn", 64'(lk_ppn), 20'hA1);
      chk("R2", "hit rd_en", 64'(lk_rd_en), 4'h3);
      chk("R2", "hit wr_en", 64'(lk_wr_en), 4'h1);
      chk("R2", "hit traps", 64'({lk_rd_trap, lk_wr_trap, lk_glob}), 3'b010);
      @(negedge clk);
      chk("R2", "lk_vld drops", 64'({lk_vld, lk_hit}), 0);
      look(20'h11, 8'h06);
      chk("R1", "foreign asn miss", 64'(lk_hit), 0);
      look(20'h12, 8'h05);
      chk("R1", "other tag miss", 64'(lk_hit), 0);
      fill(20'h22, 13'h0, 8'h09, 1, 20'hB2);
      look(20'h22, 8'h03);
      chk("R1", "global hit foreign asn", 64'({lk_hit, lk_idx, lk_glob}), {1'b1, 2'd1, 1'b1});
   endtask

   task automatic t_read();
      wipe();
      fill(20'h05, 13'h1FFF, 8'h04, 0, 20'h77);
      step();
      chk("R11", "step moves ptr", 64'(rd_ptr), 2);
      chk("R11", "empty slot invalid", 64'(rd_valid), 0);
      step();
      step();
      chk("R4", "step wraps", 64'(rd_ptr), 0);
      chk("R11", "rd fields", 64'({rd_valid, rd_vpn, rd_asn, rd_glob, rd_ppn}),
          {1'b1, 20'h05, 8'h04, 1'b0, 20'h77});
      look(20'h05, 8'h04);
      chk("R11", "step leaves slot", 64'(lk_hit), 1);
   endtask

   task automatic t_wrap();
      wipe();
      for (int i = 0; i < N; i++) fill(20'h60 + 20'(i), 13'h0, 8'h01, 0, 20'h100 + 20'(i));
      chk("R4", "fill wraps", 64'(rd_ptr), 0);
      fill(20'h70, 13'h0, 8'h01, 0, 20'h200);
      chk("R3", "ptr after evict", 64'(rd_ptr), 1);
      look(20'h60, 8'h01);
      chk("R3", "evicted miss", 64'(lk_hit), 0);
      look(20'h70, 8'h01);
      chk("R3", "new at slot0", 64'({lk_hit, lk_idx, lk_ppn}), {1'b1, 2'd0, 20'h200});
      look(20'h61, 8'h01);
      chk("R3", "neighbour kept", 64'({lk_hit, lk_idx}), {1'b1, 2'd1});
   endtask

   task automatic t_recent();
      wipe();
      fill(20'h33, 13'h0, 8'h07, 0, 20'hC0);
      fill(20'h33, 13'h0, 8'h09, 1, 20'hC1);
      look(20'h33, 8'h07);
      chk("R8", "lowest index wins", 64'(lk_idx), 0);
      look(20'h33, 8'h05);
      chk("R1", "global only", 64'(lk_idx), 1);
      look(20'h33, 8'h07);
      chk("R9", "recent list first", 64'({lk_hit, lk_idx}), {1'b1, 2'd1});
      drop_page(20'h99, 8'h07);
      look(20'h33, 8'h07);
      chk("R10", "page drop empties list", 64'({lk_hit, lk_idx}), {1'b1, 2'd0});
      look(20'h33, 8'h05);
      fill(20'h34, 13'h0, 8'h07, 0, 20'hC2);
      look(20'h33, 8'h07);
      chk("R10", "fill empties list", 64'({lk_hit, lk_idx}), {1'b1, 2'd0});
      look(20'h33, 8'h05);
      step();
      look(20'h33, 8'h07);
      chk("R10", "step keeps list", 64'(lk_idx), 1);
   endtask

   task automatic t_drops();
      wipe();
      fill(20'h40, 13'h0, 8'h01, 0, 20'hD0);
      fill(20'h41, 13'h0, 8'h01, 1, 20'hD1);
      drop_local();
      chk("R12", "drop keeps ptr", 64'(rd_ptr), 2);
      look(20'h40, 8'h01);
      chk("R6", "local dropped", 64'(lk_hit), 0);
      look(20'h41, 8'h01);
      chk("R6", "global kept", 64'({lk_hit, lk_idx}), {1'b1, 2'd1});
      wipe();
      fill(20'h44, 13'h0, 8'h02, 0, 20'hE0);
      fill(20'h44, 13'h0, 8'h03, 0, 20'hE1);
      fill(20'h45, 13'h0, 8'h06, 1, 20'hE2);
      drop_page(20'h44, 8'h02);
      look(20'h44, 8'h02);
      chk("R7", "page asn dropped", 64'(lk_hit), 0);
      look(20'h44, 8'h03);
      chk("R7", "other asn kept", 64'({lk_hit, lk_idx}), {1'b1, 2'd1});
      drop_page(20'h45, 8'h55);
      look(20'h45, 8'h00);
      chk("R7", "global page dropped", 64'(lk_hit), 0);
      chk("R12", "ptr after drops", 64'(rd_ptr), 3);
      wipe();
      chk("R5", "wipe ptr", 64'(rd_ptr), 0);
      chk("R5", "wipe slot cleared", 64'({rd_valid, rd_vpn, rd_ppn}), 0);
      look(20'h44, 8'h03);
      chk("R5", "wipe miss", 64'(lk_hit), 0);
   endtask

   task automatic t_prio();
      wipe();
      fill(20'h50, 13'h0, 8'h01, 0, 20'hF0);
      @(negedge clk);
      ins_req = 1; ins_va = {20'h51, 13'h0}; ins_asn = 8'h01; ins_glob = 0; ins_ppn = 20'hF1;
      flush_local = 1;
      @(negedge clk);
      ins_req = 0; flush_local = 0;
      chk("R12", "fill beats drop ptr", 64'(rd_ptr), 2);
      look(20'h50, 8'h01);
      chk("R12", "drop suppressed", 64'(lk_hit), 1);
      @(negedge clk);
      flush_all = 1; ins_req = 1; ins_va = {20'h52, 13'h0};
      lk_req = 1; lk_vpn = 20'h50; lk_asn = 8'h01;
      @(negedge clk);
      flush_all = 0; ins_req = 0; lk_req = 0;
      chk("R12", "lookup sees old state", 64'(lk_hit), 1);
      chk("R12", "wipe beats fill", 64'(rd_ptr), 0);
      look(20'h52, 8'h01);
      chk("R12", "fill suppressed", 64'(lk_hit), 0);
   endtask

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      t_reset();
      t_basic();
      t_read();
      t_wrap();
      t_recent();
      t_drops();
      t_prio();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule